// File: doc/BRIEF.md
# Call Trap Sequencer

This block runs the trap that a software call instruction raises. Four call variants exist, and each one vectors to its own fixed word in low memory. When the decoder pulses the call strobe, the block latches the selector, the 4-bit R field, and the current program counter, condition code and mode word. It then reads the trap instruction at the selected vector. That instruction names a block of memory through its pointer field. The block writes the old program status pair there and, for the register-saving opcode, also writes the general registers. It then reads the new program status pair from the same block.

Before the new state is handed back, the block patches it. The R field is ORed into the loaded condition code. If the add-increment flag of the trap instruction is set, the R field is also added to the loaded program counter. The saved return address is the trapping instruction's address plus one. The stored condition code is the one in force before the call.

Memory is reached through a single-request read/write port that waits for an acknowledge. The registers are read through an index/data pair.

Top module: `call_trap_seq`

## Requirements
- R1: The first memory access after an accepted strobe is a read of address 0x48 + `call_sel`, so selectors 0 to 3 map to 0x48, 0x49, 0x4A and 0x4B.
- R2: In the trap instruction, bits [AW-1:0] are the pointer P. The block writes the old status word to P: the pre-call condition code in bits [31:28], `cur_pc`+1 modulo 2^PCW in bits [PCW-1:0], and zeros elsewhere. It writes `cur_mode` to P+1.
- R3: When the trap instruction's opcode field [31:24] equals 0x13, register k (k = 0 to NREG-1) is written to P+4+k in ascending order. Any other opcode writes nothing at or above P+4.
- R4: All stores come before any load. The new status words are then read from P+2 and P+3, and the word read from P+3 appears unchanged on `new_mode`.
- R5: `new_cc` equals bits [31:28] of the word read from P+2, bitwise ORed with the captured R field.
- R6: When bit 22 of the trap instruction is 1, `new_pc` is bits [PCW-1:0] of the P+2 word plus the zero-extended R field, modulo 2^PCW. When that bit is 0, `new_pc` is those bits unchanged.
- R7: `busy` rises on the cycle after an accepted strobe and stays high until the result is ready. `done` then pulses for one cycle with `busy` low, and `new_pc`, `new_cc` and `new_mode` update in that same cycle.
- R8: A strobe that arrives while `busy` is high is ignored. It does not alter the result of the running sequence and it starts no second sequence.
- R9: `mem_req` is low whenever `busy` is low. While a request waits for `mem_ack`, its address and direction stay unchanged.
- R10: After reset, `busy`, `done` and `mem_req` are low, and `new_pc` and `new_cc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | Call instruction strobe |
| call_sel | input | 2 | Which of the four call variants |
| call_r | input | 4 | R field of the call instruction |
| cur_pc | input | PCW | Address of the trapping instruction |
| cur_cc | input | 4 | Condition code before the call |
| cur_mode | input | DW | Second word of the current status pair |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| new_pc | output | PCW | Patched program counter |
| new_cc | output | 4 | Patched condition code |
| new_mode | output | DW | Loaded second status word |
| reg_idx | output | log2(NREG) | General register being saved |
| reg_data | input | DW | Contents of register `reg_idx` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |

## Verification
A fault in the capture registers shows up in the first write after the vector read. That write carries the wrong return address or condition code, a few cycles after the strobe. A fault in the sequencer's state or register counter shows up in the order and number of memory accesses. The bench logs every access and compares the log, so a skipped, repeated or misplaced step is seen in the same sequence. A wrong patch shows only in the cycle `done` pulses, where `new_pc` and `new_cc` are compared against values recomputed from the words the bench placed in memory.

// File: rtl/call_trap_pkg.sv
package call_trap_pkg;

    localparam int CC_W        = 4;
    localparam int R_W         = 4;
    localparam int OPC_W       = 8;
    localparam int AI_FROM_MSB = 9;
    localparam logic [7:0] VEC_BASE = 8'h48;
    localparam logic [7:0] OPC_SAVE = 8'h13;

    localparam int OFS_OLD_LO = 0;
    localparam int OFS_OLD_HI = 1;
    localparam int OFS_NEW_LO = 2;
    localparam int OFS_NEW_HI = 3;
    localparam int OFS_REGS   = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VEC,
        S_OLD0,
        S_OLD1,
        S_REGS,
        S_NEW0,
        S_NEW1,
        S_FIX
    } seq_state_t;

    function automatic logic [7:0] vec_byte(input logic [1:0] sel);
        return VEC_BASE + {6'd0, sel};
    endfunction

    function automatic logic [CC_W-1:0] merge_cc(input logic [CC_W-1:0] cc,
                                                 input logic [R_W-1:0]  r);
        return cc | r;
    endfunction

endpackage

// File: rtl/ctrap_capture.sv
module ctrap_capture
    import call_trap_pkg::*;
#(
    parameter int PCW = 17,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [1:0]      call_sel,
    input  logic [R_W-1:0]  call_r,
    input  logic [PCW-1:0]  cur_pc,
    input  logic [CC_W-1:0] cur_cc,
    input  logic [DW-1:0]   cur_mode,
    output logic [1:0]      cap_sel,
    output logic [R_W-1:0]  cap_r,
    output logic [PCW-1:0]  ret_pc,
    output logic [CC_W-1:0] cap_cc,
    output logic [DW-1:0]   cap_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_sel  <= '0;
            cap_r    <= '0;
            ret_pc   <= '0;
            cap_cc   <= '0;
            cap_mode <= '0;
        end else if (take) begin
            cap_sel  <= call_sel;
            cap_r    <= call_r;
            ret_pc   <= cur_pc + PCW'(1);
            cap_cc   <= cur_cc;
            cap_mode <= cur_mode;
        end
    end

endmodule

// File: rtl/ctrap_seq.sv
module ctrap_seq
    import call_trap_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 17,
    parameter int PCW  = 17,
    parameter int NREG = 16,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      cap_sel,
    input  logic [PCW-1:0]  ret_pc,
    input  logic [CC_W-1:0] cap_cc,
    input  logic [DW-1:0]   cap_mode,
    input  logic [DW-1:0]   reg_data,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic            busy,
    output logic            fix,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [IW-1:0]   reg_idx,
    output logic            ai_q,
    output logic [CC_W-1:0] ld_cc_q,
    output logic [PCW-1:0]  ld_pc_q,
    output logic [DW-1:0]   ld_hi_q
);

    localparam int AI_POS = DW - 1 - AI_FROM_MSB;

    seq_state_t          state;
    logic [AW-1:0]       ptr_q;
    logic [OPC_W-1:0]    opc_q;
    logic [IW-1:0]       idx_q;
    logic [DW-1:0]       old_word;
    logic                save_mode;
    logic                last_reg;

    assign save_mode = (opc_q == OPC_SAVE);
    assign last_reg  = (idx_q == IW'(NREG - 1));
    assign busy      = (state != S_IDLE);
    assign fix       = (state == S_FIX);
    assign reg_idx   = idx_q;

    always_comb begin
        old_word = '0;
        old_word[DW-1 -: CC_W] = cap_cc;
        old_word[PCW-1:0]      = ret_pc;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_VEC: begin
                mem_req  = 1'b1;
                mem_addr = AW'(vec_byte(cap_sel));
            end
            S_OLD0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + AW'(OFS_OLD_LO);
                mem_wdata = old_word;
            end
            S_OLD1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + AW'(OFS_OLD_HI);
                mem_wdata = cap_mode;
            end
            S_REGS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + AW'(OFS_REGS) + AW'(idx_q);
                mem_wdata = reg_data;
            end
            S_NEW0: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'(OFS_NEW_LO);
            end
            S_NEW1: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'(OFS_NEW_HI);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            ptr_q   <= '0;
            opc_q   <= '0;
            ai_q    <= 1'b0;
            idx_q   <= '0;
            ld_cc_q <= '0;
            ld_pc_q <= '0;
            ld_hi_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) state <= S_VEC;
                S_VEC: if (mem_ack) begin
                    ptr_q <= mem_rdata[AW-1:0];
                    opc_q <= mem_rdata[DW-1 -: OPC_W];
                    ai_q  <= mem_rdata[AI_POS];
                    state <= S_OLD0;
                end
                S_OLD0: if (mem_ack) state <= S_OLD1;
                S_OLD1: if (mem_ack) begin
                    idx_q <= '0;
                    state <= save_mode ? S_REGS : S_NEW0;
                end
                S_REGS: if (mem_ack) begin
                    if (last_reg) begin
                        state <= S_NEW0;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                S_NEW0: if (mem_ack) begin
                    ld_cc_q <= mem_rdata[DW-1 -: CC_W];
                    ld_pc_q <= mem_rdata[PCW-1:0];
                    state   <= S_NEW1;
                end
                S_NEW1: if (mem_ack) begin
                    ld_hi_q <= mem_rdata;
                    state   <= S_FIX;
                end
                S_FIX:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ctrap_patch.sv
module ctrap_patch
    import call_trap_pkg::*;
#(
    parameter int PCW = 17
) (
    input  logic            ai,
    input  logic [R_W-1:0]  r,
    input  logic [CC_W-1:0] ld_cc,
    input  logic [PCW-1:0]  ld_pc,
    output logic [CC_W-1:0] out_cc,
    output logic [PCW-1:0]  out_pc
);

    logic [PCW-1:0] r_ext;

    generate
        if (PCW > R_W) begin : g_wide
            assign r_ext = {{(PCW-R_W){1'b0}}, r};
        end else begin : g_narrow
            assign r_ext = r[PCW-1:0];
        end
    endgenerate

    assign out_cc = merge_cc(ld_cc, r);
    assign out_pc = ai ? (ld_pc + r_ext) : ld_pc;

endmodule

// File: rtl/call_trap_seq.sv
module call_trap_seq
    import call_trap_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 17,
    parameter int PCW  = 17,
    parameter int NREG = 16,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            call_valid,
    input  logic [1:0]      call_sel,
    input  logic [3:0]      call_r,
    input  logic [PCW-1:0]  cur_pc,
    input  logic [3:0]      cur_cc,
    input  logic [DW-1:0]   cur_mode,
    output logic            busy,
    output logic            done,
    output logic [PCW-1:0]  new_pc,
    output logic [3:0]      new_cc,
    output logic [DW-1:0]   new_mode,
    output logic [IW-1:0]   reg_idx,
    input  logic [DW-1:0]   reg_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack
);

    logic            take;
    logic [1:0]      cap_sel;
    logic [R_W-1:0]  cap_r;
    logic [PCW-1:0]  ret_pc;
    logic [CC_W-1:0] cap_cc;
    logic [DW-1:0]   cap_mode;
    logic            fix;
    logic            ai_q;
    logic [CC_W-1:0] ld_cc_q;
    logic [PCW-1:0]  ld_pc_q;
    logic [DW-1:0]   ld_hi_q;
    logic [CC_W-1:0] patched_cc;
    logic [PCW-1:0]  patched_pc;

    assign take = call_valid && !busy;

    ctrap_capture #(.PCW(PCW), .DW(DW)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .call_sel (call_sel),
        .call_r   (call_r),
        .cur_pc   (cur_pc),
        .cur_cc   (cur_cc),
        .cur_mode (cur_mode),
        .cap_sel  (cap_sel),
        .cap_r    (cap_r),
        .ret_pc   (ret_pc),
        .cap_cc   (cap_cc),
        .cap_mode (cap_mode)
    );

    ctrap_seq #(.DW(DW), .AW(AW), .PCW(PCW), .NREG(NREG)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (take),
        .cap_sel   (cap_sel),
        .ret_pc    (ret_pc),
        .cap_cc    (cap_cc),
        .cap_mode  (cap_mode),
        .reg_data  (reg_data),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .busy      (busy),
        .fix       (fix),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .reg_idx   (reg_idx),
        .ai_q      (ai_q),
        .ld_cc_q   (ld_cc_q),
        .ld_pc_q   (ld_pc_q),
        .ld_hi_q   (ld_hi_q)
    );

    ctrap_patch #(.PCW(PCW)) u_patch (
        .ai     (ai_q),
        .r      (cap_r),
        .ld_cc  (ld_cc_q),
        .ld_pc  (ld_pc_q),
        .out_cc (patched_cc),
        .out_pc (patched_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            new_pc   <= '0;
            new_cc   <= '0;
            new_mode <= '0;
        end else begin
            done <= fix;
            if (fix) begin
                new_pc   <= patched_pc;
                new_cc   <= patched_cc;
                new_mode <= ld_hi_q;
            end
        end
    end

endmodule

// File: rtl/call_trap_chk.sv
module call_trap_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          call_valid,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    new_cc,
    input logic [1:0]    cap_sel,
    input logic [3:0]    cap_r
);

    AST_VEC_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_req && !mem_we && (mem_addr == AW'(8'h48 + {6'd0, cap_sel}))); // R1

    AST_CC_HOLDS_R: assert property (@(posedge clk) disable iff (rst)
        done |-> ((new_cc & cap_r) == cap_r)); // R5

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (call_valid && !busy) |=> busy); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req)); // R7

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && call_valid) |=> ($stable(cap_r) && $stable(cap_sel))); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R9

endmodule

bind call_trap_seq call_trap_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .call_valid (call_valid),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .new_cc     (new_cc),
    .cap_sel    (cap_sel),
    .cap_r      (cap_r)
);

// File: tb/sim_call_trap_seq.sv
module sim_call_trap_seq;

    localparam int CLK_P = 10;
    localparam int DW    = 32;
    localparam int AW    = 17;
    localparam int PCW   = 17;
    localparam int NREG  = 16;
    localparam int IW    = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            call_valid = 1'b0;
    logic [1:0]      call_sel = '0;
    logic [3:0]      call_r = '0;
    logic [PCW-1:0]  cur_pc = '0;
    logic [3:0]      cur_cc = '0;
    logic [DW-1:0]   cur_mode = '0;
    logic            busy, done;
    logic [PCW-1:0]  new_pc;
    logic [3:0]      new_cc;
    logic [DW-1:0]   new_mode;
    logic [IW-1:0]   reg_idx;
    logic [DW-1:0]   reg_data;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;
    logic            mem_ack = 1'b0;

    logic [DW-1:0]   gr_base = 32'h1000_0000;
    logic [DW-1:0]   mem [0:1023];
    logic            log_we   [0:63];
    logic [AW-1:0]   log_addr [0:63];
    int              log_n = 0;
    int              wcnt  = 0;
    int              errors = 0;
    int              checks = 0;

    always #(CLK_P/2) clk = ~clk;

    assign reg_data = gr_base + {{(DW-IW){1'b0}}, reg_idx};

    call_trap_seq #(.DW(DW), .AW(AW), .PCW(PCW), .NREG(NREG)) u0 (
        .clk(clk), .rst(rst), .call_valid(call_valid), .call_sel(call_sel),
        .call_r(call_r), .cur_pc(cur_pc), .cur_cc(cur_cc), .cur_mode(cur_mode),
        .busy(busy), .done(done), .new_pc(new_pc), .new_cc(new_cc),
        .new_mode(new_mode), .reg_idx(reg_idx), .reg_data(reg_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model with random acknowledge latency
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:0]];
                if (log_n < 64) begin
                    log_we[log_n]   <= mem_we;
                    log_addr[log_n] <= mem_addr;
                end
                log_n <= log_n + 1;
                wcnt  <= int'($urandom % 3);
            end else begin
                wcnt <= wcnt - 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [3:0] exp_cc(input logic [DW-1:0] lo, input logic [3:0] r);
        return lo[31:28] | r;
    endfunction

    function automatic logic [PCW-1:0] exp_pc(input logic ai, input logic [DW-1:0] lo,
                                              input logic [3:0] r);
        return ai ? lo[PCW-1:0] + {{(PCW-4){1'b0}}, r} : lo[PCW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_call(input logic [1:0] sel, input logic [3:0] r, input logic [3:0] cc,
                           input logic [PCW-1:0] pc, input logic [DW-1:0] mode,
                           input bit save, input bit ai, input int ptr,
                           input logic [DW-1:0] lo, input logic [DW-1:0] hi, input bit poke);
        logic [DW-1:0] tw;
        logic [DW-1:0] old0;
        int exp_n, bad, tmo;
        tw = {save ? 8'h13 : 8'h0F, 1'b0, ai, 5'd0, AW'(ptr)};
        mem[10'h48 + 10'(sel)] = tw;
        mem[ptr]   = 32'hEEEE_0000;
        mem[ptr+1] = 32'hEEEE_0001;
        mem[ptr+2] = lo;
        mem[ptr+3] = hi;
        for (int k = 0; k < NREG; k++) mem[ptr+4+k] = 32'hDEAD_0000 + k;
        gr_base = $urandom;
        log_n = 0;
        @(negedge clk);
        call_valid = 1'b1; call_sel = sel; call_r = r;
        cur_pc = pc; cur_cc = cc; cur_mode = mode;
        @(negedge clk);
        call_valid = 1'b0;
        check(busy === 1'b1, "R7 busy after strobe", 64'(busy), 64'd1);
        if (poke) begin
            @(negedge clk);
            call_valid = 1'b1; call_sel = sel + 2'd1; call_r = ~r;
            cur_pc = ~pc; cur_cc = ~cc; cur_mode = ~mode;
            @(negedge clk);
            call_valid = 1'b0;
        end
        tmo = 0;
        while (done !== 1'b1 && tmo < 500) begin
            @(negedge clk);
            tmo++;
        end
        check(tmo < 500, "R7 done reached", 64'(tmo), 64'd0);
        check(busy === 1'b0, "R7 busy low at done", 64'(busy), 64'd0);
        // access log: vector read, two stores, optional register stores, two loads
        exp_n = save ? 5 + NREG : 5;
        check(log_n == exp_n, "R3 access count", 64'(log_n), 64'(exp_n));
        check(log_we[0] == 1'b0 && log_addr[0] == AW'(8'h48 + sel), "R1 vector read",
              64'(log_addr[0]), 64'(8'h48 + sel));
        bad = 0;
        if (!(log_we[1] && log_addr[1] == AW'(ptr)))     bad++;
        if (!(log_we[2] && log_addr[2] == AW'(ptr + 1))) bad++;
        if (save)
            for (int k = 0; k < NREG; k++)
                if (!(log_we[3+k] && log_addr[3+k] == AW'(ptr + 4 + k))) bad++;
        if (!(!log_we[exp_n-2] && log_addr[exp_n-2] == AW'(ptr + 2))) bad++;
        if (!(!log_we[exp_n-1] && log_addr[exp_n-1] == AW'(ptr + 3))) bad++;
        check(bad == 0, "R4 access order", 64'(bad), 64'd0);
        old0 = '0;
        old0[31:28] = cc;
        old0[PCW-1:0] = pc + PCW'(1);
        check(mem[ptr] == old0, "R2 old status word", 64'(mem[ptr]), 64'(old0));
        check(mem[ptr+1] == mode, "R2 old mode word", 64'(mem[ptr+1]), 64'(mode));
        bad = 0;
        for (int k = 0; k < NREG; k++)
            if (mem[ptr+4+k] != (save ? gr_base + k : 32'hDEAD_0000 + k)) bad++;
        check(bad == 0, "R3 register area", 64'(bad), 64'd0);
        check(new_cc == exp_cc(lo, r), "R5 new cc", 64'(new_cc), 64'(exp_cc(lo, r)));
        check(new_pc == exp_pc(ai, lo, r), "R6 new pc", 64'(new_pc), 64'(exp_pc(ai, lo, r)));
        check(new_mode == hi, "R4 new mode", 64'(new_mode), 64'(hi));
        if (poke) begin
            repeat (3) @(negedge clk);
            check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0,
                  "R8 no second sequence", 64'({busy, done, mem_req}), 64'd0);
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd7141));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R10 control reset",
              64'({busy, done, mem_req}), 64'd0);
        check(new_pc == '0 && new_cc == '0, "R10 result reset", 64'({new_pc, new_cc}), 64'd0);
        // directed corners
        do_call(2'd0, 4'h0, 4'h5, 17'h1FFFF, 32'h1234_5678, 1'b0, 1'b1, 'h100,
                32'hA001_2345, 32'h5555_AAAA, 1'b0);                            // R2 wrap, R6 r=0
        do_call(2'd3, 4'hF, 4'h0, 17'h00010, 32'h0, 1'b1, 1'b1, 'h200,
                32'h0001_FFFF, 32'hFFFF_0000, 1'b0);                            // R6 wrap, R3 save
        do_call(2'd1, 4'h9, 4'hC, 17'h0ABCD, 32'hCAFE_F00D, 1'b0, 1'b0, 'h300,
                32'h6000_0100, 32'h0BAD_BEEF, 1'b1);                            // R8 poke, R6 ai=0
        do_call(2'd2, 4'h6, 4'h3, 17'h00000, 32'h1, 1'b1, 1'b0, 'h180,
                32'h3000_0042, 32'h7777_7777, 1'b1);                            // R1 sel 2, R8
        // constrained random
        for (int n = 0; n < 40; n++) begin
            do_call(2'($urandom), 4'($urandom), 4'($urandom), PCW'($urandom),
                    $urandom, 1'($urandom), 1'($urandom), 'h100 + int'($urandom % 'h2C0),
                    $urandom, $urandom, ($urandom % 4) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule